// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block is a non-blocking time-slot interchange for serial TDM streams. Several serial input streams and several serial output streams share one bit clock and one frame pulse. Every frame, each input stream delivers a fixed number of 8-bit channels, which the block stores in a two-page data memory. For every output timeslot, one connection memory entry says what to transmit. The entry can name any channel of any input stream, or it can supply a constant byte written by a processor. Each entry also picks between lowest-latency delivery and a fixed one-frame delay that keeps every channel of an input frame together.

A processor reaches the block through a single-cycle synchronous register port. Through that port it can write and read back connection entries, read the most recently completed input frame from the data memory, and set or read a control register that gates the outputs. Any number of output timeslots may name the same source, so one input channel can be broadcast to many outputs.

Top module: `tsi_switch`

## Requirements
- R1: After reset, every serial output stays at 1 until the first clock edge that samples the frame pulse high.
- R2: The cycle after the edge that samples the frame pulse high carries bit 0 of the frame. Timeslot t occupies bits 8t to 8t+7, there are 32 timeslots per frame, and both input and output bytes are sent MSB first.
- R3: In connection mode, an output timeslot sends the byte received on the named input stream and channel. One source can feed any number of output timeslots at the same time.
- R4: When entry bit 9 (message) is set, the output timeslot sends entry bits 7:0.
- R5: When bits 9 and 8 are both clear (variable delay), an output timeslot t sourced from channel c sends the byte from the current frame if c+2 <= t, and the byte from the previous frame otherwise.
- R6: When bit 8 (constant delay) is set, the output timeslot always sends the byte from the previous input frame. This includes source channel 31 mapped to output timeslot 0.
- R7: A connection entry is 10 bits wide: bit 9 message, bit 8 constant delay, bits 6:5 source stream, bits 4:0 source channel. The entry for output stream o and timeslot t sits at address {2'b00, o, t}, and a write there reads back unchanged.
- R8: Port address bits 8:7 select the space: 00 connection memory, 01 data memory, 10 control register. A read returns its data on cpu_rdata one cycle later. A data-memory read of {2'b01, s, c} returns {2'b00, byte} of channel c of stream s from the last completed input frame.
- R9: Control register bit 0 is the output enable and resets to 1. While it is 0, every serial output drives 1.
- R10: A connection write landing on the same clock edge at which that entry is loaded for transmission does not affect that timeslot in the current frame. It takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock shared by all streams |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_i | input | 1 | Frame pulse, high for one clock ahead of bit 0 |
| ser_in | input | 4 | Serial input streams |
| ser_out | output | 4 | Serial output streams |
| cpu_sel | input | 1 | Port access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 9 | {space, stream, channel} |
| cpu_wdata | input | 10 | Write data |
| cpu_rdata | output | 10 | Read data, valid the cycle after a read |

## Verification
Two events can fall on the same edge: a processor write to a connection entry, and the output load that consumes that same entry. The bench waits for the negative edge just before output timeslot 10 is loaded, issues the write there, and its scoreboard expects the old mapping for that timeslot and the new one from the next frame on. A second coincidence happens at every frame boundary: the last input channel is written on the same edge that loads output timeslot 0. The constant-delay mapping of channel 31 to timeslot 0 checks that the freshly completed byte is forwarded in that case.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
   localparam int BYTE_W = 8;
   localparam int CM_W   = BYTE_W + 2;

   typedef struct packed {
      logic              msg;
      logic              cdly;
      logic [BYTE_W-1:0] val;
   } cm_entry_t;

   typedef enum logic [1:0] {
      SP_CONN = 2'b00,
      SP_DATA = 2'b01,
      SP_CTRL = 2'b10,
      SP_NONE = 2'b11
   } space_e;
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer #(
   parameter int SLOT_W = 5,
   localparam int BIT_W = SLOT_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fp_i,
   output logic [BIT_W-1:0]  bcnt,
   output logic              page,
   output logic              next_page,
   output logic              synced,
   output logic              load,
   output logic [SLOT_W-1:0] load_slot,
   output logic              rx_done,
   output logic [SLOT_W-1:0] rx_slot
);
   logic [BIT_W-1:0] nxt;

   assign nxt       = fp_i ? '0 : bcnt + 1'b1;
   assign next_page = page ^ fp_i;
   // the byte for the coming timeslot is loaded on the edge before it starts
   assign load      = (synced | fp_i) && (nxt[2:0] == 3'd0);
   assign load_slot = nxt[BIT_W-1:3];
   assign rx_done   = synced && (bcnt[2:0] == 3'd7);
   assign rx_slot   = bcnt[BIT_W-1:3];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bcnt   <= '0;
         page   <= 1'b0;
         synced <= 1'b0;
      end else begin
         bcnt <= nxt;
         if (fp_i) begin
            page   <= ~page;
            synced <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/tsi_rx_bank.sv
module tsi_rx_bank #(
   parameter int N_SLOTS = 32,
   parameter int N_RD    = 4,
   localparam int CW     = $clog2(N_SLOTS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sin,
   input  logic                     done,
   input  logic [CW-1:0]            wr_slot,
   input  logic                     wr_page,
   input  logic [N_RD-1:0]          rd_page,
   input  logic [N_RD-1:0][CW-1:0]  rd_chan,
   output logic [N_RD-1:0][7:0]     rd_byte,
   input  logic                     cpu_page,
   input  logic [CW-1:0]            cpu_chan,
   output logic [7:0]               cpu_byte
);
   logic [6:0] shreg;
   logic [7:0] wbyte;
   logic [7:0] mem [2*N_SLOTS];

   assign wbyte = {shreg, sin};

   always_ff @(posedge clk) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[5:0], sin};
   end

   always_ff @(posedge clk) begin
      if (done) mem[{wr_page, wr_slot}] <= wbyte;
   end

   for (genvar r = 0; r < N_RD; r++) begin : g_rd
      logic hit;
      // forward a byte completing on this very edge (frame-boundary case)
      assign hit        = done && ({rd_page[r], rd_chan[r]} == {wr_page, wr_slot});
      assign rd_byte[r] = hit ? wbyte : mem[{rd_page[r], rd_chan[r]}];
   end

   assign cpu_byte = mem[{cpu_page, cpu_chan}];
endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] tx_byte,
   input  logic       en,
   output logic       sout
);
   logic [7:0] sreg;

   always_ff @(posedge clk) begin
      if (!rst_n)    sreg <= '1;
      else if (load) sreg <= tx_byte;
      else           sreg <= {sreg[6:0], 1'b1};
   end

   assign sout = en ? sreg[7] : 1'b1;
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
   import tsi_pkg::*;
#(
   parameter int N_STREAMS = 4,
   parameter int N_SLOTS   = 32,
   localparam int SW       = $clog2(N_STREAMS),
   localparam int CW       = $clog2(N_SLOTS),
   localparam int AW       = 2 + SW + CW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fp_i,
   input  logic [N_STREAMS-1:0] ser_in,
   output logic [N_STREAMS-1:0] ser_out,
   input  logic                 cpu_sel,
   input  logic                 cpu_wr,
   input  logic [AW-1:0]        cpu_addr,
   input  logic [CM_W-1:0]      cpu_wdata,
   output logic [CM_W-1:0]      cpu_rdata
);
   if (N_STREAMS < 2 || (1 << SW) != N_STREAMS) begin : g_bad_streams
      $error("N_STREAMS must be a power of two >= 2");
   end
   if (N_SLOTS < 4 || (1 << CW) != N_SLOTS) begin : g_bad_slots
      $error("N_SLOTS must be a power of two >= 4");
   end
   if (SW + CW > BYTE_W) begin : g_bad_entry
      $error("source stream and channel must fit the entry byte");
   end

   logic [CW+2:0] bcnt;
   logic          page, next_page, synced, load, rx_done;
   logic [CW-1:0] load_slot, rx_slot;

   tsi_frame_timer #(.SLOT_W(CW)) i_timer (
      .clk, .rst_n, .fp_i, .bcnt, .page, .next_page, .synced,
      .load, .load_slot, .rx_done, .rx_slot
   );

   // ---------------- processor port ----------------
   space_e        sp;
   logic [CW-1:0] a_chan;
   logic [SW-1:0] a_strm;
   logic          ctrl_en;
   logic          wr_cm;
   cm_entry_t     cmem [N_STREAMS*N_SLOTS];
   logic [N_STREAMS-1:0][7:0] bank_cpu;

   assign sp     = space_e'(cpu_addr[AW-1:AW-2]);
   assign a_chan = cpu_addr[CW-1:0];
   assign a_strm = cpu_addr[SW+CW-1:CW];
   assign wr_cm  = cpu_sel && cpu_wr && (sp == SP_CONN);

   always_ff @(posedge clk) begin
      if (wr_cm) cmem[cpu_addr[SW+CW-1:0]] <= cpu_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_en   <= 1'b1;
         cpu_rdata <= '0;
      end else if (cpu_sel) begin
         if (cpu_wr) begin
            if (sp == SP_CTRL) ctrl_en <= cpu_wdata[0];
         end else begin
            unique case (sp)
               SP_CONN: cpu_rdata <= cmem[cpu_addr[SW+CW-1:0]];
               SP_DATA: cpu_rdata <= {2'b00, bank_cpu[a_strm]};
               SP_CTRL: cpu_rdata <= {{(CM_W-1){1'b0}}, ctrl_en};
               default: cpu_rdata <= '0;
            endcase
         end
      end
   end

   // ---------------- per-output lookup ----------------
   logic [N_STREAMS-1:0]                    rpage;
   logic [N_STREAMS-1:0][CW-1:0]            rchan;
   logic [N_STREAMS-1:0][N_STREAMS-1:0][7:0] bank_rd;

   for (genvar o = 0; o < N_STREAMS; o++) begin : g_out
      cm_entry_t     ent;
      logic [SW-1:0] src_s;
      logic          use_cur;
      logic [7:0]    tx_byte;

      assign ent     = cmem[{SW'(o), load_slot}];
      assign src_s   = ent.val[SW+CW-1:CW];
      assign rchan[o] = ent.val[CW-1:0];
      // current frame only if the source byte completed two slots earlier
      assign use_cur = !ent.cdly &&
                       (({1'b0, rchan[o]} + (CW+1)'(2)) <= {1'b0, load_slot});
      assign rpage[o] = use_cur ? next_page : ~next_page;
      assign tx_byte = ent.msg ? ent.val : bank_rd[src_s][o];

      tsi_tx_lane i_lane (
         .clk, .rst_n, .load, .tx_byte,
         .en   (synced & ctrl_en),
         .sout (ser_out[o])
      );
   end

   for (genvar s = 0; s < N_STREAMS; s++) begin : g_in
      tsi_rx_bank #(.N_SLOTS(N_SLOTS), .N_RD(N_STREAMS)) i_bank (
         .clk, .rst_n,
         .sin      (ser_in[s]),
         .done     (rx_done),
         .wr_slot  (rx_slot),
         .wr_page  (page),
         .rd_page  (rpage),
         .rd_chan  (rchan),
         .rd_byte  (bank_rd[s]),
         .cpu_page (~page),
         .cpu_chan (a_chan),
         .cpu_byte (bank_cpu[s])
      );
   end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
   parameter int N_STREAMS = 4,
   parameter int N_SLOTS   = 32,
   localparam int SW       = $clog2(N_STREAMS),
   localparam int CW       = $clog2(N_SLOTS),
   localparam int AW       = 2 + SW + CW
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 fp_i,
   input logic [N_STREAMS-1:0] ser_out,
   input logic                 cpu_sel,
   input logic                 cpu_wr,
   input logic [AW-1:0]        cpu_addr,
   input logic [9:0]           cpu_wdata,
   input logic                 ctrl_en,
   input logic [CW+2:0]        bcnt,
   input logic                 page
);
   logic seen_fp;

   always_ff @(posedge clk) begin
      if (!rst_n)    seen_fp <= 1'b0;
      else if (fp_i) seen_fp <= 1'b1;
   end

   AST_PRESYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_fp |-> (ser_out == '1)); // R1
   AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      fp_i |=> (bcnt == '0)); // R2
   AST_PAGE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      fp_i |=> (page != $past(page))); // R5
   AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fp_i |=> (page == $past(page))); // R6
   AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_sel && cpu_wr && cpu_addr[AW-1:AW-2] == 2'b10) |=> (ctrl_en == $past(cpu_wdata[0]))); // R8
   AST_MUTED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |-> (ser_out == '1)); // R9
endmodule

bind tsi_switch tsi_switch_chk #(.N_STREAMS(N_STREAMS), .N_SLOTS(N_SLOTS)) i_chk (
   .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .ser_out(ser_out),
   .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
   .ctrl_en(ctrl_en), .bcnt(bcnt), .page(page)
);

// File: tb/test_tsi_switch.sv
module test_tsi_switch;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       fp_i;
   logic [3:0] ser_in, ser_out;
   logic       cpu_sel, cpu_wr;
   logic [8:0] cpu_addr;
   logic [9:0] cpu_wdata, cpu_rdata;

   tsi_switch i_tsi_switch (.*);

   always #5 clk = ~clk;

   int vecs = 0, errs = 0;
   int p, fr;
   bit run = 0, hold = 0, coll_on = 0, finished = 0;
   logic [9:0] shadow [4][32];
   logic [7:0] obyte [4];

   typedef struct packed {
      logic       chk;
      logic [1:0] kind;
      logic [7:0] b;
   } exp_t;
   exp_t q[$];

   function automatic logic [7:0] in_byte(int f, int s, int c);
      return 8'((f * 29 + s * 83 + c * 7 + 17) ^ (c << 3));
   endfunction

   function automatic exp_t expect_slot(int f, int o, int t);
      exp_t e;
      logic [9:0] ent = shadow[o][t];
      int s = int'(ent[6:5]);
      int c = int'(ent[4:0]);
      e.chk = (f >= 3) && !hold;
      if (ent[9]) begin
         e.kind = 2'd2;
         e.b    = ent[7:0];
      end else begin
         e.kind = ent[8] ? 2'd1 : 2'd0;
         e.b    = in_byte((!ent[8] && c + 2 <= t) ? f : f - 1, s, c);
      end
      if (coll_on && o == 0 && t == 10) e.kind = 2'd3;
      return e;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver for serial inputs and frame pulse, monitor for serial outputs (R2)
   always @(negedge clk) begin
      if (run) begin
         logic [7:0] ib;
         fp_i = (p == 255);
         for (int s = 0; s < 4; s++) begin
            ib = in_byte(fr, s, p / 8);
            ser_in[s] = ib[7 - p % 8];
         end
         for (int o = 0; o < 4; o++) obyte[o] = {obyte[o][6:0], ser_out[o]};
         if (p % 8 == 7) begin
            for (int o = 0; o < 4; o++) begin
               if (q.size() > 0) begin
                  exp_t e = q.pop_front();
                  if (e.chk) begin
                     string tag;
                     case (e.kind)
                        2'd0: tag = "R5 variable delay (R3 R2)";
                        2'd1: tag = "R6 constant delay";
                        2'd2: tag = "R4 message";
                        default: tag = "R10 write at load edge";
                     endcase
                     check(obyte[o] == e.b, tag, obyte[o], e.b);
                  end
               end
            end
            for (int o = 0; o < 4; o++)
               q.push_back(expect_slot((p == 255) ? fr + 1 : fr, o, ((p + 1) / 8) % 32));
         end
         p  <= (p == 255) ? 0 : p + 1;
         fr <= (p == 255) ? fr + 1 : fr;
      end
   end

   task automatic cpu_write(logic [8:0] a, logic [9:0] d, int at_p);
      if (at_p < 0) @(negedge clk);
      else do @(negedge clk); while (p != at_p);
      cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
      @(posedge clk); #1;
      cpu_sel = 0; cpu_wr = 0;
      if (a[8:7] == 2'b00) shadow[a[6:5]][a[4:0]] = d;
   endtask

   task automatic cpu_read(logic [8:0] a, output logic [9:0] d, output int frd);
      @(negedge clk);
      frd = fr;
      cpu_sel = 1; cpu_wr = 0; cpu_addr = a;
      @(posedge clk); #1;
      cpu_sel = 0;
      @(negedge clk);
      d = cpu_rdata;
   endtask

   function automatic logic [9:0] conn(bit m, bit cd, int s, int c);
      return {m, cd, 1'b0, 2'(s), 5'(c)};
   endfunction

   initial begin
      logic [9:0] rd;
      int frd;
      rst_n = 0; fp_i = 0; ser_in = '0;
      cpu_sel = 0; cpu_wr = 0; cpu_addr = '0; cpu_wdata = '0;
      p = 255; fr = -1;
      for (int o = 0; o < 4; o++) for (int t = 0; t < 32; t++) shadow[o][t] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         check(ser_out == 4'hF, "R1 idle before frame pulse", ser_out, 4'hF);
      end
      cpu_read(9'h100, rd, frd);
      check(rd == 10'h001, "R9 enable reset value", rd, 10'h001);

      for (int t = 0; t < 32; t++) begin
         cpu_write({2'b00, 2'd0, 5'(t)}, conn(0, 0, t % 4, 31 - t), -1);
         cpu_write({2'b00, 2'd1, 5'(t)}, conn(0, 1, t % 4, 31 - t), -1);
         cpu_write({2'b00, 2'd2, 5'(t)}, (t % 2 == 0) ? {2'b10, 8'(8'hA0 + t)}
                                                      : conn(0, 0, 0, 5), -1);
         cpu_write({2'b00, 2'd3, 5'(t)},
                   conn(0, 0, 1, (t % 2 == 0) ? ((t >= 2) ? t - 2 : 31) : t - 1), -1);
      end
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         check(ser_out == 4'hF, "R1 idle after programming", ser_out, 4'hF);
      end
      cpu_read({2'b00, 2'd2, 5'd4}, rd, frd);
      check(rd == {2'b10, 8'hA4}, "R7 entry readback", rd, {2'b10, 8'hA4});
      cpu_read({2'b00, 2'd1, 5'd3}, rd, frd);
      check(rd == conn(0, 1, 3, 28), "R7 entry readback", rd, conn(0, 1, 3, 28));

      run = 1;
      repeat (6 * 256) @(negedge clk);

      for (int k = 0; k < 6; k++) begin
         int s = k % 4, c = (k * 11) % 32;
         logic [9:0] ex;
         cpu_read({2'b01, 2'(s), 5'(c)}, rd, frd);
         ex = {2'b00, in_byte(frd - 1, s, c)};
         check(rd == ex, "R8 data memory read", rd, ex);
      end

      coll_on = 1;
      cpu_write({2'b00, 2'd0, 5'd10}, conn(0, 0, 3, 0), 79);
      repeat (3 * 256) @(negedge clk);
      coll_on = 0;

      hold = 1;
      repeat (20) @(negedge clk);
      cpu_write(9'h100, 10'h000, -1);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         check(ser_out == 4'hF, "R9 outputs muted", ser_out, 4'hF);
      end
      cpu_read(9'h100, rd, frd);
      check(rd == 10'h000, "R8 control readback", rd, 10'h000);
      cpu_write(9'h100, 10'h001, -1);
      repeat (20) @(negedge clk);
      hold = 0;
      repeat (3 * 256) @(negedge clk);

      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         finished = 1;
         check(0, "watchdog", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end
endmodule